// File: doc/BRIEF.md
# Key-Guarded Flash Program/Erase Front-End

This block sits between a register bus and a flash array macro. Software loads a target address, chooses between programming and page erase with a configuration bit, and then writes the data register to launch one operation on the macro. The flash array, its read path and its timing belong to the macro. This block only issues one-cycle program or erase strobes, holds a busy flag until the macro answers with a done pulse, and keeps a sticky error bit for writes it refuses.

Every launch is guarded by a key sequencer. An arming key followed by a one-shot key opens the gate for exactly one accepted data write. An arming key followed by a stay-open key keeps the gate open until any further key write closes it. Any unexpected key value drops the sequencer back to fully locked.

The register map uses byte offsets. The configuration register is at 0x00, with a set view at 0x04 and a clear view at 0x08. The write address is at 0x10, write data at 0x14 and the key at 0x18. In the configuration word, bit 2 is the sticky error, bit 18 is erase mode and bit 20 is the read-only busy flag.

Top module: `flash_keyguard`

## Requirements
- R1: After reset the configuration word reads 0 (no error, erase mode off, not busy), the write address reads 0, and the sequencer is locked.
- R2: A write to offset 0x00 loads erase mode from bit 18. A write to 0x04 sets erase mode when bit 18 is 1. A write to 0x08 clears erase mode when bit 18 is 1. Other bits of such a write leave erase mode unchanged.
- R3: Configuration bit 20 (busy) goes high in the cycle after an accepted data write. It stays high until the cycle after the macro's done pulse.
- R4: Key 0xA5 followed by key 0xF1 (keys are the low byte of a write to 0x18) allows exactly one accepted data write. After that write the sequencer is locked again.
- R5: Key 0xA5 followed by key 0xF2 allows any number of data writes. They remain allowed until key 0x5A is written, which locks the sequencer.
- R6: A key value that is not the expected next value locks the sequencer and keeps no partial progress. For example, 0xA5, 0xA5, 0xF1 leaves writes refused.
- R7: With erase mode off, an accepted data write issues a program strobe. The strobe carries the stored write address and bits 15:0 of the written word. Afterwards the write address has advanced by 2.
- R8: With erase mode on, an accepted data write issues an erase strobe. The strobe address is the write address rounded down to a 1024-byte page. The written value is ignored and the write address is left unchanged.
- R9: A data write while locked or while busy launches nothing and sets the sticky error bit (bit 2). Only a write to 0x08 with bit 2 set clears the error bit.
- R10: The program and erase strobes are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the addressed register (combinational) |
| fl_addr | output | FA_W | Byte address presented to the flash macro |
| fl_wdata | output | 16 | Halfword to program |
| fl_prog | output | 1 | One-cycle program request |
| fl_erase | output | 1 | One-cycle page-erase request |
| fl_done | input | 1 | Macro completion pulse |
| busy | output | 1 | Operation in flight |

## Verification
The bench attacks the key sequencer with three patterns:
- A one-shot unlock followed by a second data write. A sequencer that failed to relock would let the second write through as an extra program strobe.
- A stay-open unlock closed with the closing key.
- A repeated arming key. A design that kept partial progress would accept the write that follows.

A data write issued while a program is still in flight must produce no strobe and must raise the error bit. A design that checks only the key state would start an overlapping operation instead.

The erase test uses an address in the middle of a page. This exposes a macro address that was not page-rounded, and a write address that moved after an erase.

// File: rtl/flkg_pkg.sv
package flkg_pkg;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_ONCE   = 2'd2,
    KS_OPEN   = 2'd3
  } key_st_e;

  localparam logic [7:0] KEY_ARM   = 8'hA5;
  localparam logic [7:0] KEY_ONCE  = 8'hF1;
  localparam logic [7:0] KEY_OPEN  = 8'hF2;
  localparam logic [7:0] KEY_CLOSE = 8'h5A;

  localparam int OFS_CFG     = 'h00;
  localparam int OFS_CFG_SET = 'h04;
  localparam int OFS_CFG_CLR = 'h08;
  localparam int OFS_WADDR   = 'h10;
  localparam int OFS_WDATA   = 'h14;
  localparam int OFS_KEY     = 'h18;

  localparam int BIT_ERR   = 2;
  localparam int BIT_ERASE = 18;
  localparam int BIT_BUSY  = 20;

  function automatic logic [31:0] halfword_next(input logic [31:0] a);
    return a + 32'd2;
  endfunction

  function automatic logic [31:0] page_floor(input logic [31:0] a, input int unsigned lsb);
    return (a >> lsb) << lsb;
  endfunction

  function automatic key_st_e key_step(input key_st_e s, input logic key_wr,
                                       input logic [7:0] k, input logic consume);
    key_st_e n;
    n = s;
    case (s)
      KS_LOCKED: if (key_wr) n = (k == KEY_ARM) ? KS_ARMED : KS_LOCKED;
      KS_ARMED: begin
        if (key_wr) begin
          if (k == KEY_ONCE)      n = KS_ONCE;
          else if (k == KEY_OPEN) n = KS_OPEN;
          else                    n = KS_LOCKED;
        end
      end
      KS_ONCE: if (key_wr || consume) n = KS_LOCKED;
      KS_OPEN: if (key_wr) n = KS_LOCKED;
      default: n = KS_LOCKED;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/flkg_key_seq.sv
module flkg_key_seq
  import flkg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       consume,
  output logic       key_open
);

  key_st_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= KS_LOCKED;
    else        state <= key_step(state, key_wr, key_byte, consume);
  end

  assign key_open = (state == KS_ONCE) || (state == KS_OPEN);

  // R4
  oneshot_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == KS_ONCE && consume) |=> (state == KS_LOCKED));

  // R6
  bad_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == KS_ARMED && key_wr && key_byte != KEY_ONCE && key_byte != KEY_OPEN)
      |=> (state == KS_LOCKED));

  // R5
  open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == KS_OPEN && !key_wr) |=> (state == KS_OPEN));

  // R5
  close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == KS_OPEN && key_wr && key_byte == KEY_CLOSE) |=> !key_open);

endmodule

// File: rtl/flkg_cfg_regs.sv
module flkg_cfg_regs
  import flkg_pkg::*;
#(
  parameter int FA_W = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic            set_wr,
  input  logic            clr_wr,
  input  logic            waddr_wr,
  input  logic            erase_bit,
  input  logic            err_bit,
  input  logic [FA_W-1:1] waddr_in,
  input  logic            reject,
  input  logic            launch,
  output logic            erase_en,
  output logic            err,
  output logic [FA_W-1:0] waddr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      erase_en <= 1'b0;
    end else if (cfg_wr) begin
      erase_en <= erase_bit;
    end else if (set_wr && erase_bit) begin
      erase_en <= 1'b1;
    end else if (clr_wr && erase_bit) begin
      erase_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  err <= 1'b0;
    else if (reject)             err <= 1'b1;
    else if (clr_wr && err_bit)  err <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    waddr <= '0;
    else if (waddr_wr)             waddr <= {waddr_in, 1'b0};
    else if (launch && !erase_en)  waddr <= FA_W'(halfword_next(32'(waddr)));
  end

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !erase_en) |=> (waddr == $past(waddr) + FA_W'(2)));

  // R8
  erase_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && erase_en) |=> $stable(waddr));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr_wr) |=> err);

endmodule

// File: rtl/flkg_op_launch.sv
module flkg_op_launch
  import flkg_pkg::*;
#(
  parameter int FA_W       = 18,
  parameter int PAGE_BYTES = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic            erase_en,
  input  logic [FA_W-1:0] waddr,
  input  logic [15:0]     hword,
  input  logic            fl_done,
  output logic            fl_prog,
  output logic            fl_erase,
  output logic [FA_W-1:0] fl_addr,
  output logic [15:0]     fl_wdata,
  output logic            busy
);

  localparam int unsigned PAGE_LSB = $clog2(PAGE_BYTES);

  logic [FA_W-1:0] page_addr;
  assign page_addr = FA_W'(page_floor(32'(waddr), PAGE_LSB));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_prog  <= 1'b0;
      fl_erase <= 1'b0;
      fl_addr  <= '0;
      fl_wdata <= '0;
    end else begin
      fl_prog  <= launch && !erase_en;
      fl_erase <= launch && erase_en;
      if (launch) begin
        fl_addr  <= erase_en ? page_addr : waddr;
        fl_wdata <= erase_en ? 16'h0000 : hword;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       busy <= 1'b0;
    else if (launch)  busy <= 1'b1;
    else if (fl_done) busy <= 1'b0;
  end

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_prog, fl_erase}));

  // R10
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_prog || fl_erase) |=> !(fl_prog || fl_erase));

  // R3
  busy_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_prog || fl_erase) |-> busy);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fl_done) |=> busy);

  // R8
  erase_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_erase |-> (fl_addr[PAGE_LSB-1:0] == '0));

endmodule

// File: rtl/flash_keyguard.sv
module flash_keyguard
  import flkg_pkg::*;
#(
  parameter int FA_W       = 18,
  parameter int PAGE_BYTES = 1024,
  parameter int RA_W       = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic [FA_W-1:0] fl_addr,
  output logic [15:0]     fl_wdata,
  output logic            fl_prog,
  output logic            fl_erase,
  input  logic            fl_done,
  output logic            busy
);

  logic cfg_wr, set_wr, clr_wr, waddr_wr, data_wr, key_wr;
  logic key_open, launch, reject;
  logic erase_en, err;
  logic [FA_W-1:0] waddr;
  logic [31:0] cfg_view;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[31:19];

  assign cfg_wr   = reg_wr && (reg_addr == RA_W'(OFS_CFG));
  assign set_wr   = reg_wr && (reg_addr == RA_W'(OFS_CFG_SET));
  assign clr_wr   = reg_wr && (reg_addr == RA_W'(OFS_CFG_CLR));
  assign waddr_wr = reg_wr && (reg_addr == RA_W'(OFS_WADDR));
  assign data_wr  = reg_wr && (reg_addr == RA_W'(OFS_WDATA));
  assign key_wr   = reg_wr && (reg_addr == RA_W'(OFS_KEY));

  assign launch = data_wr && key_open && !busy;
  assign reject = data_wr && !launch;

  flkg_key_seq u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_byte (reg_wdata[7:0]),
    .consume  (launch),
    .key_open (key_open)
  );

  flkg_cfg_regs #(.FA_W(FA_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .set_wr    (set_wr),
    .clr_wr    (clr_wr),
    .waddr_wr  (waddr_wr),
    .erase_bit (reg_wdata[BIT_ERASE]),
    .err_bit   (reg_wdata[BIT_ERR]),
    .waddr_in  (reg_wdata[FA_W-1:1]),
    .reject    (reject),
    .launch    (launch),
    .erase_en  (erase_en),
    .err       (err),
    .waddr     (waddr)
  );

  flkg_op_launch #(.FA_W(FA_W), .PAGE_BYTES(PAGE_BYTES)) u_op (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .erase_en (erase_en),
    .waddr    (waddr),
    .hword    (reg_wdata[15:0]),
    .fl_done  (fl_done),
    .fl_prog  (fl_prog),
    .fl_erase (fl_erase),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata),
    .busy     (busy)
  );

  always_comb begin
    cfg_view            = '0;
    cfg_view[BIT_ERR]   = err;
    cfg_view[BIT_ERASE] = erase_en;
    cfg_view[BIT_BUSY]  = busy;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RA_W'(OFS_CFG) || reg_addr == RA_W'(OFS_CFG_SET) ||
        reg_addr == RA_W'(OFS_CFG_CLR))
      reg_rdata = cfg_view;
    else if (reg_addr == RA_W'(OFS_WADDR))
      reg_rdata = 32'(waddr);
  end

  // R9
  locked_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !key_open) |=> !(fl_prog || fl_erase));

  // R9
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> (err && !(fl_prog || fl_erase)));

endmodule

// File: tb/flash_keyguard_bench.sv
`timescale 1ns/1ps
module flash_keyguard_bench;

  localparam int FA_W = 18;
  localparam int RA_W = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0;
  logic [RA_W-1:0] reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [FA_W-1:0] fl_addr;
  logic [15:0]     fl_wdata;
  logic            fl_prog, fl_erase, busy;
  logic            fl_done;

  always #2 clk = ~clk;

  flash_keyguard u_flash_keyguard (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_prog(fl_prog), .fl_erase(fl_erase),
    .fl_done(fl_done), .busy(busy)
  );

  // behavioural flash stand-in: 16 cycles program, 64 cycles erase
  int fcnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      fcnt <= 0; fl_done <= 1'b0;
    end else begin
      fl_done <= 1'b0;
      if (fl_prog) fcnt <= 16;
      else if (fl_erase) fcnt <= 64;
      else if (fcnt != 0) begin
        fcnt <= fcnt - 1;
        if (fcnt == 1) fl_done <= 1'b1;
      end
    end
  end

  typedef struct { bit er; logic [FA_W-1:0] a; logic [15:0] d; } op_t;
  op_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor
  bit prev_strobe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (fl_prog && fl_erase) check("R10 both strobes", 32'd1, 32'd0);
      if ((fl_prog || fl_erase) && prev_strobe) check("R10 strobe width", 32'd2, 32'd1);
      if ((fl_prog || fl_erase) && !prev_strobe) begin
        if (sb_q.size() == 0) check("R9 unexpected strobe", 32'd1, 32'd0);
        else begin
          op_t e;
          e = sb_q.pop_front();
          check(e.er ? "R8 erase kind" : "R7 program kind", 32'(fl_erase), 32'(e.er));
          check(e.er ? "R8 erase addr" : "R7 program addr", 32'(fl_addr), 32'(e.a));
          if (!e.er) check("R7 program data", 32'(fl_wdata), 32'(e.d));
        end
      end
      prev_strobe = fl_prog || fl_erase;
    end
  end

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = RA_W'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = RA_W'(a);
    #1 d = reg_rdata;
  endtask

  task automatic push(input bit er, input logic [FA_W-1:0] a, input logic [15:0] d);
    op_t e;
    e.er = er; e.a = a; e.d = d;
    sb_q.push_back(e);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      bus_rd('h00, v);
      if (!v[20]) break;
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd('h00, v); check("R1 cfg after reset", v, 32'h0);
    bus_rd('h10, v); check("R1 waddr after reset", v, 32'h0);
    bus_wr('h14, 32'h1); bus_rd('h00, v);
    check("R1 locked after reset (R9 err)", v, 32'h0000_0004);
    bus_wr('h08, 32'h4); bus_rd('h00, v); check("R9 err cleared", v, 32'h0);

    // R2 config views
    bus_wr('h04, 32'h0004_0000); bus_rd('h00, v); check("R2 set view", v, 32'h0004_0000);
    bus_wr('h08, 32'h0000_0004); bus_rd('h00, v); check("R2 clear other bit keeps erase", v, 32'h0004_0000);
    bus_wr('h08, 32'h0004_0000); bus_rd('h00, v); check("R2 clear view", v, 32'h0);
    bus_wr('h00, 32'h0004_0000); bus_rd('h04, v); check("R2 direct write", v, 32'h0004_0000);
    bus_wr('h00, 32'h0); bus_rd('h00, v); check("R2 direct write 0", v, 32'h0);

    // R4 one-shot unlock, R7 program, R3 busy
    bus_wr('h10, 32'h1234);
    bus_wr('h18, 32'hA5); bus_wr('h18, 32'hF1);
    push(0, 18'h1234, 16'hBEEF);
    bus_wr('h14, 32'hDEAD_BEEF);
    bus_rd('h00, v); check("R3 busy after launch", v, 32'h0010_0000);
    wait_idle();
    bus_rd('h00, v); check("R3 busy cleared after done", v, 32'h0);
    bus_rd('h10, v); check("R7 address advanced", v, 32'h1236);
    bus_wr('h14, 32'h0000_7777);
    bus_rd('h00, v); check("R4 second write refused", v, 32'h0000_0004);
    bus_wr('h08, 32'h4);

    // R5 multiple unlock, R9 busy reject
    bus_wr('h18, 32'hA5); bus_wr('h18, 32'hF2);
    push(0, 18'h1236, 16'h2222);
    bus_wr('h14, 32'h1111_2222);
    bus_wr('h14, 32'h9999_9999);
    bus_rd('h00, v); check("R9 write while busy", v, 32'h0010_0004);
    wait_idle();
    bus_wr('h08, 32'h4);
    push(0, 18'h1238, 16'h4444);
    bus_wr('h14, 32'h3333_4444);
    wait_idle();
    bus_rd('h00, v); check("R5 still open, no error", v, 32'h0);
    bus_wr('h18, 32'h5A);
    bus_wr('h14, 32'h5555_6666);
    bus_rd('h00, v); check("R5 relocked by close key", v, 32'h0000_0004);
    bus_wr('h08, 32'h4);

    // R6 wrong key sequences
    bus_wr('h18, 32'hA5); bus_wr('h18, 32'hA5); bus_wr('h18, 32'hF1);
    bus_wr('h14, 32'h1);
    bus_rd('h00, v); check("R6 repeated arm refused", v, 32'h0000_0004);
    bus_wr('h08, 32'h4);
    bus_wr('h18, 32'hA5); bus_wr('h18, 32'h33); bus_wr('h18, 32'hF2);
    bus_wr('h14, 32'h1);
    bus_rd('h00, v); check("R6 bad key then open refused", v, 32'h0000_0004);
    bus_wr('h08, 32'h4);

    // R8 erase
    bus_wr('h04, 32'h0004_0000);
    bus_wr('h10, 32'h2ABC);
    bus_wr('h18, 32'hA5); bus_wr('h18, 32'hF1);
    push(1, 18'h2800, 16'h0);
    bus_wr('h14, 32'h0000_5555);
    bus_rd('h00, v); check("R8 busy during erase", v, 32'h0014_0000);
    wait_idle();
    bus_rd('h10, v); check("R8 address unchanged", v, 32'h2ABC);
    bus_rd('h00, v); check("R8 idle, no error", v, 32'h0004_0000);

    repeat (10) @(negedge clk);
    check("R7 scoreboard drained", 32'(sb_q.size()), 32'd0);
    summary();
    $finish;
  end

endmodule